// File: doc/BRIEF.md
# Modem Status Register for a 16550-Class UART

This block holds the modem status byte of a 16550-compatible serial port. It appears at register offset 6. The divisor-latch access bit has no effect on it. Four active-low modem handshake inputs are brought into the clock domain through synchroniser chains. The upper nibble of the byte shows each line's asserted level, which is the complement of the pin. The lower nibble holds sticky change flags. A read of the register clears these flags, and while any flag is set the block can raise a modem-status interrupt request.

In the self-test (loopback) mode, the upper nibble and the change detection take four modem-control outputs of the port in place of the external pins. Software can then toggle those outputs and watch the status bits and the interrupt follow. The bus decoder and every other register of the UART sit outside this block. The block only receives a one-cycle read strobe for this offset.

Top module: `uart_modem_status`

## Requirements
- R1: While reset is asserted, and directly after it with all pins high and loopback off, `statusByte` reads 0x00 and `modemIrq` is 0.
- R2: Bit 0 sets on every level change of the clear-to-send line (`modemPinN[0]`), rising or falling, and stays set until the register is read.
- R3: Bit 2 sets only when the ring line (`modemPinN[2]`) goes from 0 to 1, which is the end of a ring. A 1-to-0 transition of that pin leaves bit 2 clear.
- R4: Bit 1 sets on every level change of the data-set-ready line (`modemPinN[1]`). Bit 3 sets on every level change of the carrier-detect line (`modemPinN[3]`).
- R5: A cycle with `regRead` high still presents the flags as they were before the read. From the next cycle, bits 3:0 are clear unless a new change arrived.
- R6: `modemIrq` is high exactly when `intEn` is high and at least one of bits 3:0 is set.
- R7: With loopback off, bits 4, 5, 6 and 7 show the inverted levels of `modemPinN[0]`, `[1]`, `[2]` and `[3]` respectively.
- R8: With `loopEn` high, the pins are ignored. Bits 4, 5, 6 and 7 show `loopCtl[0]` (request to send), `[1]` (terminal ready), `[2]` (aux output 1) and `[3]` (aux output 2). Changes of these bits set the flags under the same edge rules as R2 to R4.
- R9: A change detected in the same cycle as a read leaves its flag set after that read.
- R10: A pin change first appears in the status byte after the third rising clock edge: two synchroniser stages and then the level register. A `loopCtl` change appears after the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modemPinN | input | NUM_LINES | Active-low modem inputs: [0] clear to send, [1] data set ready, [2] ring, [3] carrier detect |
| loopEn | input | 1 | Loopback mode enable |
| loopCtl | input | NUM_LINES | Modem-control outputs used in loopback: [0] RTS, [1] DTR, [2] OUT1, [3] OUT2 |
| regRead | input | 1 | One-cycle read strobe for this register |
| intEn | input | 1 | Modem-status interrupt enable |
| statusByte | output | 2*NUM_LINES | Register value: change flags in the low half, levels in the high half |
| modemIrq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach from the ports is a change that lands on the same clock edge as a read. A pin change passes through a synchroniser, so the bench cannot easily line it up with the read strobe. The bench therefore uses loopback. There a `loopCtl` change reaches the change detector on the very next edge, so the bench raises the control bit and `regRead` in the same cycle. It then confirms that the flag survives. The three-edge pin latency is measured edge by edge before the bench relies on it.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrDelta;  // read of the register: clear change flags
    logic useLoop;   // take levels from modem-control outputs
  } mstatStrobe_t;
endpackage

// File: rtl/mstat_dpath.sv
module mstat_dpath
  import mstat_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] TRAIL_MASK = 4'b0100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinN,
  input  logic [NUM_LINES-1:0] loopSrc,
  input  mstatStrobe_t         strobe,
  output logic [NUM_LINES-1:0] lvlQ,
  output logic [NUM_LINES-1:0] deltaQ
);
  logic [NUM_LINES-1:0] srcLvl;
  logic [NUM_LINES-1:0] change;

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], pinN[i]};
    end

    assign srcLvl[i] = strobe.useLoop ? loopSrc[i] : ~chain[SYNC_STAGES-1];

    if (TRAIL_MASK[i]) begin : gTrail
      // flag only when the asserted level drops (pin 0 -> 1)
      assign change[i] = lvlQ[i] & ~srcLvl[i];

      // R3: a trailing-only flag rises only together with a falling level
      a_r3_trail_only: assert property (@(posedge clk) disable iff (!rstN)
        $rose(deltaQ[i]) |-> $fell(lvlQ[i]));
    end else begin : gAny
      assign change[i] = lvlQ[i] ^ srcLvl[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ   <= '0;
      deltaQ <= '0;
    end else begin
      lvlQ   <= srcLvl;
      deltaQ <= (strobe.clrDelta ? '0 : deltaQ) | change;
    end
  end

  // R2: flags are sticky while no read happens
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrDelta |=> ((deltaQ & $past(deltaQ)) == $past(deltaQ)));

  // R5: a read with no fresh change leaves all flags clear
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrDelta && (change == '0)) |=> (deltaQ == '0));

  // R9: a detected change is never lost, even on a read cycle
  a_r9_change_kept: assert property (@(posedge clk) disable iff (!rstN)
    (change != '0) |=> ((deltaQ & $past(change)) == $past(change)));

  // R8: in loopback the levels follow the control outputs one edge later
  a_r8_loop_levels: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.useLoop && $past(strobe.useLoop)) |-> (lvlQ == $past(loopSrc)));
endmodule

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
  import mstat_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regRead,
  input  logic                 loopEn,
  input  logic                 intEn,
  input  logic [NUM_LINES-1:0] deltaQ,
  output mstatStrobe_t         strobe,
  output logic                 modemIrq
);
  always_comb begin
    strobe.clrDelta = regRead;
    strobe.useLoop  = loopEn;
  end

  assign modemIrq = intEn & (|deltaQ);

  // R6: with the enable held, the request only drops after a read
  a_r6_irq_drop: assert property (@(posedge clk) disable iff (!rstN)
    (intEn && $past(intEn) && $fell(modemIrq)) |-> $past(regRead));
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import mstat_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] TRAIL_MASK = 4'b0100,
  localparam int STAT_W = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] modemPinN,
  input  logic                 loopEn,
  input  logic [NUM_LINES-1:0] loopCtl,
  input  logic                 regRead,
  input  logic                 intEn,
  output logic [STAT_W-1:0]    statusByte,
  output logic                 modemIrq
);
  mstatStrobe_t         strobe;
  logic [NUM_LINES-1:0] lvlQ;
  logic [NUM_LINES-1:0] deltaQ;

  mstat_ctrl #(.NUM_LINES(NUM_LINES)) uCtrl (
    .clk(clk), .rstN(rstN), .regRead(regRead), .loopEn(loopEn),
    .intEn(intEn), .deltaQ(deltaQ), .strobe(strobe), .modemIrq(modemIrq)
  );

  mstat_dpath #(
    .NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES), .TRAIL_MASK(TRAIL_MASK)
  ) uDpath (
    .clk(clk), .rstN(rstN), .pinN(modemPinN), .loopSrc(loopCtl),
    .strobe(strobe), .lvlQ(lvlQ), .deltaQ(deltaQ)
  );

  assign statusByte = {lvlQ, deltaQ};

  // R1: nothing is reported straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> (statusByte == '0));
endmodule

// File: tb/uart_modem_status_test.sv
module uart_modem_status_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] modemPinN = 4'hF;
  logic       loopEn = 1'b0;
  logic [3:0] loopCtl = 4'h0;
  logic       regRead = 1'b0;
  logic       intEn = 1'b1;
  logic [7:0] statusByte;
  logic       modemIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_modem_status uut (
    .clk(clk), .rstN(rstN), .modemPinN(modemPinN), .loopEn(loopEn),
    .loopCtl(loopCtl), .regRead(regRead), .intEn(intEn),
    .statusByte(statusByte), .modemIrq(modemIrq)
  );

  // Vector fields: pinsN[19:16] loop[15] ctl[14:11] ie[10] rd[9] exp[8:1] irq[0]
  localparam logic [19:0] VECS [0:13] = '{
    {4'hF, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0}, // R1 idle
    {4'hE, 1'b0, 4'h0, 1'b1, 1'b1, 8'h11, 1'b1}, // R2 R7 cts asserts
    {4'hE, 1'b0, 4'h0, 1'b1, 1'b0, 8'h10, 1'b0}, // R5 cleared
    {4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 8'h01, 1'b1}, // R2 cts deasserts
    {4'hB, 1'b0, 4'h0, 1'b1, 1'b0, 8'h40, 1'b0}, // R3 pin 1->0: no flag
    {4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 8'h04, 1'b1}, // R3 pin 0->1: flag
    {4'hD, 1'b0, 4'h0, 1'b0, 1'b1, 8'h22, 1'b0}, // R4 R6 dsr, irq masked
    {4'h5, 1'b0, 4'h0, 1'b1, 1'b1, 8'hA8, 1'b1}, // R4 dcd asserts
    {4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 8'h0A, 1'b1}, // R4 both drop
    {4'hF, 1'b1, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0}, // R8 enter loopback
    {4'hF, 1'b1, 4'h5, 1'b1, 1'b1, 8'h51, 1'b1}, // R8 rts, out1
    {4'h0, 1'b1, 4'h4, 1'b1, 1'b1, 8'h41, 1'b1}, // R8 pins ignored
    {4'hF, 1'b1, 4'hA, 1'b1, 1'b1, 8'hAE, 1'b1}, // R8 R3 out1 trailing
    {4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 8'h0A, 1'b1}  // R8 leave loopback
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readPulse();
    regRead = 1'b1;
    edges(1);
    regRead = 1'b0;
  endtask

  initial begin
    edges(2);
    chk("R1 in reset", statusByte, 8'h00);
    chk("R1 irq in reset", {7'd0, modemIrq}, 8'h00);
    rstN = 1'b1;
    edges(3);
    chk("R1 after reset", statusByte, 8'h00);

    for (int i = 0; i < 14; i++) begin
      modemPinN = VECS[i][19:16];
      loopEn    = VECS[i][15];
      loopCtl   = VECS[i][14:11];
      intEn     = VECS[i][10];
      edges(4);
      chk($sformatf("vec%0d status", i), statusByte, VECS[i][8:1]);
      chk($sformatf("vec%0d irq R6", i), {7'd0, modemIrq}, {7'd0, VECS[i][0]});
      if (VECS[i][9]) readPulse();
    end

    // R10: pin latency of three edges
    modemPinN = 4'hE;
    edges(1);
    chk("R10 edge1", statusByte, 8'h00);
    edges(1);
    chk("R10 edge2", statusByte, 8'h00);
    edges(1);
    chk("R10 edge3", statusByte, 8'h11);
    modemPinN = 4'hF;
    edges(4);
    chk("R2 drop flag", statusByte, 8'h01);

    // R5: read cycle shows pre-clear value, then cleared
    regRead = 1'b1;
    #0;
    chk("R5 during read", statusByte, 8'h01);
    edges(1);
    regRead = 1'b0;
    chk("R5 after read", statusByte, 8'h00);

    // R9: change on the same edge as a read survives; R10 loopback latency 1
    loopEn = 1'b1;
    loopCtl = 4'h0;
    edges(2);
    loopCtl = 4'h1;
    regRead = 1'b1;
    edges(1);
    regRead = 1'b0;
    chk("R9 change kept on read", statusByte, 8'h11);
    chk("R9 irq", {7'd0, modemIrq}, 8'h01);
    readPulse();
    chk("R9 cleared later", statusByte, 8'h10);

    // R1: reset mid-run wipes flags and levels
    loopCtl = 4'h0;
    edges(1);
    chk("R2 loop drop", statusByte, 8'h01);
    rstN = 1'b0;
    edges(1);
    chk("R1 mid reset", statusByte, 8'h00);
    chk("R1 mid reset irq", {7'd0, modemIrq}, 8'h00);
    rstN = 1'b1;
    edges(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule